// File: doc/BRIEF.md
# Nonvolatile Memory Access Control Unit

This block owns the 8-bit control and status register that software uses to drive an on-chip nonvolatile memory. It also owns the small sequencer that turns register writes into memory-side requests. Software picks a target space (data EEPROM, program flash or configuration) and chooses between a plain write and a row erase. It arms writes with an enable bit and launches operations by setting one-shot start bits.

A read request becomes a single-cycle strobe, and its start bit drops again by itself. A write or erase request becomes a single-cycle start pulse, after which the block waits for the memory to report completion. While it waits, it shows busy.

A warm reset that lands during a self-timed cycle aborts that cycle. The abort raises a sticky error flag and leaves the space and erase selections in place, so software can see what was cut short. The storage array, its programming delay, the address and data registers and any unlock sequence all sit outside this block.

Top module: `nvm_ctrl_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_rdata` reads 0x00, `busy` is 0, `mem_start` is 0 and `wr_done_pulse` is 0.
- R2: A CPU write loads bit 7 (program space), bit 6 (configuration space), bit 4 (row erase), bit 3 (error) and bit 2 (write enable) from `cpu_wdata`, and they read back on the next cycle. Bit 5 always reads 0. Writing 0 to bit 1 or bit 0 has no effect on them.
- R3: Writing 1 to bit 1 starts a cycle only if bit 2 was already 1 before that write and no cycle is busy. Otherwise bit 1 stays unchanged and no start pulse is issued.
- R4: On the cycle after a start is accepted, bit 1 and `busy` are 1 and `mem_start` is high for exactly one cycle. `mem_op` is then 2'b11 (erase) if the written bit 4 is 1, otherwise 2'b10 (write).
- R5: `mem_space` is 2'b10 when the written bit 6 is 1, otherwise 2'b01 when the written bit 7 is 1, otherwise 2'b00.
- R6: `mem_done` while busy ends the cycle. On the next cycle bit 1 and `busy` are 0, bit 3 is 0, and `wr_done_pulse` is high for that one cycle only.
- R7: A write with bit 0 = 1 and bit 7 = 0 starts a read when the unit is not busy and no write starts in the same access. The next cycle shows bit 0 = 1 with `mem_start` high and `mem_op` = 2'b01. One cycle later bit 0 and `mem_start` are 0.
- R8: A write with bit 0 = 1 and bit 7 = 1 leaves bit 0 at 0 and issues no read strobe.
- R9: If an access sets both bit 1 and bit 0 and the write start is accepted, only the write starts.
- R10: A `warm_rst` while busy ends the cycle without `wr_done_pulse` and sets bit 3. It keeps bits 7, 6 and 4, and clears bits 2, 1 and 0.
- R11: A `warm_rst` while idle clears bits 2 and 0 and leaves bits 7, 6, 4 and 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm (pin or watchdog) reset, synchronous, active high |
| cpu_wr_en | input | 1 | CPU writes the control register this cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Control register read value |
| mem_start | output | 1 | One-cycle request strobe to the memory |
| mem_op | output | 2 | Request kind: 01 read, 10 write, 11 erase, 00 none |
| mem_space | output | 2 | Target: 00 data EEPROM, 01 program flash, 10 configuration |
| mem_done | input | 1 | Memory reports the self-timed cycle finished |
| busy | output | 1 | A write or erase cycle is in progress |
| wr_done_pulse | output | 1 | One-cycle pulse on normal completion |

## Verification
The properties assume that `rst` is held for at least one clock before any check applies. They also assume that `mem_done` arrives no earlier than the cycle after a start has been seen. The bench keeps to both conditions. It holds reset for several cycles and raises `mem_done` only after it has observed `busy`. It drops `mem_done` and `warm_rst` after one cycle, so no completion can overlap a following request. The sweep covers every write value against both prior states of the enable bit.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int CTRL_W = 8;
  localparam int OP_W   = 2;
  localparam int SP_W   = 2;

  // Bit positions that software relies on
  localparam int B_PROG  = 7;
  localparam int B_CFG   = 6;
  localparam int B_ERASE = 4;
  localparam int B_ERR   = 3;
  localparam int B_WEN   = 2;
  localparam int B_WGO   = 1;
  localparam int B_RGO   = 0;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_ERASE = 2'b11
  } nvm_op_e;

  typedef enum logic [SP_W-1:0] {
    SP_DATA = 2'b00,
    SP_PROG = 2'b01,
    SP_CFG  = 2'b10
  } nvm_space_e;
endpackage

// File: rtl/nvm_req_decode.sv
module nvm_req_decode
  import nvm_pkg::*;
(
  input  logic       cpu_wr_en,
  input  logic       wd_prog,
  input  logic       wd_cfg,
  input  logic       wd_erase,
  input  logic       wd_wgo,
  input  logic       wd_rgo,
  input  logic       wen_q,
  input  logic       busy_q,
  input  logic       warm_rst,
  output logic       wr_go,
  output logic       rd_go,
  output nvm_op_e    go_op,
  output nvm_space_e go_space
);
  logic idle_access;

  always_comb begin
    idle_access = cpu_wr_en && !busy_q && !warm_rst;
    // write start needs the enable already set before this access
    wr_go = idle_access && wd_wgo && wen_q;
    // read refused in program space; an accepted write takes priority
    rd_go = idle_access && wd_rgo && !wd_prog && !wr_go;

    if (wr_go)      go_op = wd_erase ? OP_ERASE : OP_WRITE;
    else if (rd_go) go_op = OP_READ;
    else            go_op = OP_NONE;

    if (wd_cfg)       go_space = SP_CFG;
    else if (wd_prog) go_space = SP_PROG;
    else              go_space = SP_DATA;
  end
endmodule

// File: rtl/nvm_csr.sv
module nvm_csr
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cpu_wr_en,
  input  logic [CTRL_W-1:0] cpu_wdata,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic              mem_done,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              wen_q,
  output logic              busy_q
);
  logic prog_q, cfg_q, erase_q, err_q, wgo_q, rgo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b0;
      cfg_q   <= 1'b0;
      erase_q <= 1'b0;
      err_q   <= 1'b0;
      wen_q   <= 1'b0;
      wgo_q   <= 1'b0;
      rgo_q   <= 1'b0;
    end else if (warm_rst) begin
      // space and erase selections survive for post-mortem tracing
      wen_q <= 1'b0;
      wgo_q <= 1'b0;
      rgo_q <= 1'b0;
      if (wgo_q) err_q <= 1'b1;
    end else begin
      if (cpu_wr_en) begin
        prog_q  <= cpu_wdata[B_PROG];
        cfg_q   <= cpu_wdata[B_CFG];
        erase_q <= cpu_wdata[B_ERASE];
        err_q   <= cpu_wdata[B_ERR];
        wen_q   <= cpu_wdata[B_WEN];
      end
      if (wgo_q && mem_done) err_q <= 1'b0;
      rgo_q <= rd_go;
      if (wr_go)         wgo_q <= 1'b1;
      else if (mem_done) wgo_q <= 1'b0;
    end
  end

  assign busy_q = wgo_q;

  always_comb begin
    ctrl_q          = '0;
    ctrl_q[B_PROG]  = prog_q;
    ctrl_q[B_CFG]   = cfg_q;
    ctrl_q[B_ERASE] = erase_q;
    ctrl_q[B_ERR]   = err_q;
    ctrl_q[B_WEN]   = wen_q;
    ctrl_q[B_WGO]   = wgo_q;
    ctrl_q[B_RGO]   = rgo_q;
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            warm_rst,
  input  logic            wr_go,
  input  logic            rd_go,
  input  nvm_op_e         go_op,
  input  nvm_space_e      go_space,
  input  logic            busy_q,
  input  logic            mem_done,
  output logic            mem_start,
  output logic [OP_W-1:0] mem_op,
  output logic [SP_W-1:0] mem_space,
  output logic            wr_done_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_start     <= 1'b0;
      mem_op        <= OP_NONE;
      mem_space     <= SP_DATA;
      wr_done_pulse <= 1'b0;
    end else begin
      mem_start     <= wr_go || rd_go;
      mem_op        <= go_op;
      if (wr_go || rd_go) mem_space <= go_space;
      wr_done_pulse <= busy_q && mem_done && !warm_rst;
    end
  end
endmodule

// File: rtl/nvm_ctrl_unit.sv
module nvm_ctrl_unit
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cpu_wr_en,
  input  logic [CTRL_W-1:0] cpu_wdata,
  output logic [CTRL_W-1:0] cpu_rdata,
  output logic              mem_start,
  output logic [OP_W-1:0]   mem_op,
  output logic [SP_W-1:0]   mem_space,
  input  logic              mem_done,
  output logic              busy,
  output logic              wr_done_pulse
);
  logic       wr_go, rd_go, wen_q, busy_q;
  nvm_op_e    go_op;
  nvm_space_e go_space;
  logic       unused_wd5;

  assign unused_wd5 = cpu_wdata[5];

  nvm_req_decode i_dec (
    .cpu_wr_en (cpu_wr_en),
    .wd_prog   (cpu_wdata[B_PROG]),
    .wd_cfg    (cpu_wdata[B_CFG]),
    .wd_erase  (cpu_wdata[B_ERASE]),
    .wd_wgo    (cpu_wdata[B_WGO]),
    .wd_rgo    (cpu_wdata[B_RGO]),
    .wen_q     (wen_q),
    .busy_q    (busy_q),
    .warm_rst  (warm_rst),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .go_op     (go_op),
    .go_space  (go_space)
  );

  nvm_csr i_csr (
    .clk       (clk),
    .rst       (rst),
    .warm_rst  (warm_rst),
    .cpu_wr_en (cpu_wr_en),
    .cpu_wdata (cpu_wdata),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .mem_done  (mem_done),
    .ctrl_q    (cpu_rdata),
    .wen_q     (wen_q),
    .busy_q    (busy_q)
  );

  nvm_seq i_seq (
    .clk           (clk),
    .rst           (rst),
    .warm_rst      (warm_rst),
    .wr_go         (wr_go),
    .rd_go         (rd_go),
    .go_op         (go_op),
    .go_space      (go_space),
    .busy_q        (busy_q),
    .mem_done      (mem_done),
    .mem_start     (mem_start),
    .mem_op        (mem_op),
    .mem_space     (mem_space),
    .wr_done_pulse (wr_done_pulse)
  );

  assign busy = busy_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              warm_rst,
  input logic [CTRL_W-1:0] cpu_rdata,
  input logic              mem_start,
  input logic [OP_W-1:0]   mem_op,
  input logic              busy,
  input logic              wr_done_pulse
);
  // R7
  read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[B_RGO] |-> (mem_start && mem_op == OP_READ));

  // R8
  no_prog_read_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[B_RGO] |-> !cpu_rdata[B_PROG]);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_start && mem_op[1]));

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cpu_rdata[B_WEN]));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done_pulse |-> ($past(busy) && !busy));

  // R10
  abort_err_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && busy) |=> (cpu_rdata[B_ERR] && !busy && !wr_done_pulse));

  // R10
  abort_trace_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_rst && busy) |=> (cpu_rdata[B_PROG] == $past(cpu_rdata[B_PROG])
                            && cpu_rdata[B_ERASE] == $past(cpu_rdata[B_ERASE])));

  // R2
  bit5_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rdata[5]);
endmodule

bind nvm_ctrl_unit nvm_ctrl_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .warm_rst      (warm_rst),
  .cpu_rdata     (cpu_rdata),
  .mem_start     (mem_start),
  .mem_op        (mem_op),
  .busy          (busy),
  .wr_done_pulse (wr_done_pulse)
);

// File: tb/test_nvm_ctrl_unit.sv
module test_nvm_ctrl_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, warm_rst, cpu_wr_en, mem_done;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       mem_start, busy, wr_done_pulse;
  logic [1:0] mem_op, mem_space;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_ctrl_unit i_nvm_ctrl_unit (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .cpu_wr_en(cpu_wr_en),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_start(mem_start),
    .mem_op(mem_op), .mem_space(mem_space), .mem_done(mem_done),
    .busy(busy), .wr_done_pulse(wr_done_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] v);
    cpu_wr_en = 1'b1;
    cpu_wdata = v;
    step();
    cpu_wr_en = 1'b0;
    cpu_wdata = 8'h00;
  endtask

  function automatic logic [1:0] space_of(input logic [7:0] v);
    return v[6] ? 2'b10 : (v[7] ? 2'b01 : 2'b00);
  endfunction

  initial begin
    rst = 1'b1; warm_rst = 1'b0; cpu_wr_en = 1'b0; cpu_wdata = 8'h00; mem_done = 1'b0;
    repeat (3) step();
    chk("R1 rdata in reset", cpu_rdata, 8'h00);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    step();
    chk("R1 rdata after reset", cpu_rdata, 8'h00);
    chk("R1 start after reset", mem_start, 0);
    chk("R1 done pulse after reset", wr_done_pulse, 0);

    // Sweep: every write value against both prior enable states
    for (int pre = 0; pre < 2; pre++) begin
      for (int vi = 0; vi < 256; vi++) begin
        logic [7:0] v;
        logic exp_wr, exp_rd;
        logic [7:0] exp_rd_val;
        logic [1:0] exp_op;
        v = 8'(vi);
        cpu_write(pre[0] ? 8'h04 : 8'h00);
        chk("R2 preset", cpu_rdata, pre[0] ? 8'h04 : 8'h00);
        exp_wr = v[1] && pre[0];                 // R3 R9
        exp_rd = v[0] && !v[7] && !exp_wr;       // R7 R8
        exp_rd_val = {v[7], v[6], 1'b0, v[4], v[3], v[2], exp_wr, exp_rd};
        exp_op = exp_wr ? (v[4] ? 2'b11 : 2'b10) : (exp_rd ? 2'b01 : 2'b00);
        cpu_write(v);
        chk("R2 R3 R8 rdata", cpu_rdata, exp_rd_val);
        chk("R4 R7 start", mem_start, exp_wr | exp_rd);
        chk("R4 R7 op", mem_op, exp_op);
        if (exp_wr | exp_rd) chk("R5 space", mem_space, space_of(v));
        chk("R4 busy", busy, exp_wr);
        step();
        chk("R4 R7 start one cycle", mem_start, 0);
        if (exp_rd) chk("R7 read bit self-clears", cpu_rdata[0], 0);
        if (exp_wr) begin
          chk("R4 busy held", busy, 1);
          mem_done = 1'b1;
          step();
          mem_done = 1'b0;
          chk("R6 rdata after done", cpu_rdata, {v[7], v[6], 1'b0, v[4], 1'b0, v[2], 2'b00});
          chk("R6 busy clear", busy, 0);
          chk("R6 done pulse", wr_done_pulse, 1);
          step();
          chk("R6 done pulse one cycle", wr_done_pulse, 0);
        end
      end
    end

    // R3 / R2: start attempts while busy are ignored
    cpu_write(8'h04);
    cpu_write(8'h06);
    chk("R4 busy set", busy, 1);
    cpu_write(8'h06);
    chk("R3 busy restart ignored", mem_start, 0);
    cpu_write(8'h04);
    chk("R2 zero to write bit ignored", cpu_rdata[1], 1);
    chk("R2 zero to write bit busy", busy, 1);
    mem_done = 1'b1; step(); mem_done = 1'b0;
    chk("R6 done", busy, 0);

    // R10: warm reset aborting an erase in configuration space
    cpu_write(8'h04);
    cpu_write(8'hD6);
    chk("R4 erase op", mem_op, 2'b11);
    chk("R5 cfg space", mem_space, 2'b10);
    step();
    warm_rst = 1'b1; step(); warm_rst = 1'b0;
    chk("R10 rdata after abort", cpu_rdata, 8'hD8);
    chk("R10 busy after abort", busy, 0);
    chk("R10 no done pulse", wr_done_pulse, 0);
    step();
    chk("R10 error sticky", cpu_rdata, 8'hD8);

    // R11: warm reset while idle
    cpu_write(8'h5C);
    warm_rst = 1'b1; step(); warm_rst = 1'b0;
    chk("R11 idle warm reset", cpu_rdata, 8'h58);
    chk("R11 no busy", busy, 0);

    // R1: power-on reset clears everything
    cpu_write(8'hDC);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 re-reset", cpu_rdata, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule